// File: doc/BRIEF.md
# Nibble-Sliced 16-bit Arithmetic Logic Unit

This block is a purely combinational 16-bit arithmetic logic unit. It is built from four identical 4-bit slices connected as a ripple chain. Each slice takes the matching nibble of both operands, and the slice outputs are joined to form the result. A 3-bit operation code selects one of seven slice operations or a byte exchange. A separate rotate control overrides the operation code and turns the chain into a one-place rotator of operand A, in either direction.

Alongside the result, the block drives an 8-bit flag vector. The flags give the carry out of every slice, full-width operand equality, sign, a zero indication and an overflow indication. The overflow term is qualified by a subtract control input. A sequencer outside the block owns the flag register and decides when the outputs are captured.

Top module: `alu16`

## Requirements
- R1: With op_i = 0 (add) and rot_i = 0, result_o equals (A + B + cin_i) mod 2^16, and flag bit 3 (top carry) equals bit 16 of that sum.
- R2: With op_i = 1 (subtract) and rot_i = 0, result_o equals (A + ~B + cin_i) mod 2^16, so cin_i = 1 yields A − B. Flag bit 3 equals bit 16 of that sum (1 means no borrow).
- R3: With rot_i = 0, op_i codes 2, 3, 4, 5 and 6 give A AND B, A OR B, A XOR B, NOT A and B respectively. Flag bits 3:0 are all 0 for these codes.
- R4: With op_i = 7 and rot_i = 0, result_o equals {A[7:0], A[15:8]} and flag bits 3:0 are 0.
- R5: For add and subtract, flag bits 0, 1 and 2 are the carries out of result bits 3, 7 and 11 of the same sum.
- R6: Flag bit 4 is 1 exactly when A equals B over all 16 bits, whatever the operation.
- R7: Flag bit 5 equals result_o[15]. Flag bit 6 is 1 when result_o is zero or when A is zero.
- R8: Flag bit 7 equals (NOT(A[15] OR sub_i) AND result_o[15]) OR (A[15] AND NOT result_o[15]).
- R9: With rot_i = 1 and rot_right_i = 0, result_o equals {A[14:0], A[15]}. The carry flags are A[3], A[7], A[11] and A[15] in bits 0 to 3. op_i, B and cin_i have no effect on result_o or on flag bits 3:0.
- R10: With rot_i = 1 and rot_right_i = 1, result_o equals {A[0], A[15:1]}. The carry flags are A[12], A[8], A[4] and A[0] in bits 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| op_i | input | 3 | Operation code (0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 NOT A, 6 pass B, 7 byte exchange) |
| sub_i | input | 1 | Subtract qualifier for the overflow flag |
| cin_i | input | 1 | External carry into the lowest slice |
| rot_i | input | 1 | Rotate A by one place; overrides op_i |
| rot_right_i | input | 1 | Rotate direction: 0 left, 1 right |
| result_o | output | 16 | Result |
| flags_o | output | 8 | Flags: [0..3] slice carries, [4] equal, [5] negative, [6] zero, [7] overflow |

## Verification
The bench builds the block with its default slice width of four bits, which gives four slices and a 16-bit datapath. At that size the four corner operands 0x0000, 0x7FFF, 0x8000 and 0xFFFF can be crossed exhaustively with every operation code, both rotate directions and both carry-in values. That cross drives the inter-slice carries, the wrapped rotate carry and the overflow sign flips to their extremes. Random operands then cover the nibble-level carry patterns between those extremes.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int unsigned ALU_SLICES = 4;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_AND   = 3'd2,
        OP_OR    = 3'd3,
        OP_XOR   = 3'd4,
        OP_NOTA  = 3'd5,
        OP_PASSB = 3'd6,
        OP_SWAP  = 3'd7
    } alu_op_e;

    // bit 0 = lowest slice carry ... bit 7 = overflow
    typedef struct packed {
        logic                  ovf;
        logic                  zero;
        logic                  neg;
        logic                  eq;
        logic [ALU_SLICES-1:0] cy;
    } alu_flags_t;

    function automatic logic is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/alu_slice.sv
module alu_slice
    import alu16_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  alu_op_e      op_i,
    input  logic         cin_i,
    input  logic         eq_i,
    output logic [W-1:0] y_o,
    output logic         cout_o,
    output logic         eq_o
);
    logic [W-1:0] b_eff;
    logic [W:0]   sum;

    always_comb begin
        b_eff = (op_i == OP_SUB) ? ~b_i : b_i;
        sum   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
        cout_o = 1'b0;
        unique case (op_i)
            OP_ADD, OP_SUB: begin
                y_o    = sum[W-1:0];
                cout_o = sum[W];
            end
            OP_AND:   y_o = a_i & b_i;
            OP_OR:    y_o = a_i | b_i;
            OP_XOR:   y_o = a_i ^ b_i;
            OP_NOTA:  y_o = ~a_i;
            OP_PASSB: y_o = b_i;
            default:  y_o = a_i;
        endcase
    end

    assign eq_o = eq_i & (a_i == b_i);

    always_comb begin
        if (!is_arith(op_i)) begin
            assert_logic_no_carry_R3: assert (cout_o == 1'b0)
                else $error("slice carry set on a logic operation");
        end
    end

endmodule

// File: rtl/alu_flags.sv
module alu_flags
    import alu16_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic [DW-1:0]         a_i,
    input  logic [DW-1:0]         y_i,
    input  logic                  sub_i,
    input  logic                  eq_i,
    input  logic [ALU_SLICES-1:0] cy_i,
    output alu_flags_t            flags_o
);
    logic a_msb;
    logic y_msb;

    assign a_msb = a_i[DW-1];
    assign y_msb = y_i[DW-1];

    always_comb begin
        flags_o.cy   = cy_i;
        flags_o.eq   = eq_i;
        flags_o.neg  = y_msb;
        flags_o.zero = (y_i == '0) || (a_i == '0);
        flags_o.ovf  = (~(a_msb | sub_i) & y_msb) | (a_msb & ~y_msb);
    end

    always_comb begin
        if (sub_i && !a_msb) begin
            assert_sub_pos_no_ovf_R8: assert (flags_o.ovf == 1'b0)
                else $error("overflow set for non-negative A under subtract");
        end
    end

endmodule

// File: rtl/alu16.sv
module alu16
    import alu16_pkg::*;
#(
    parameter int unsigned SLICE_W = 4
) (
    input  logic [SLICE_W*ALU_SLICES-1:0] a_i,
    input  logic [SLICE_W*ALU_SLICES-1:0] b_i,
    input  logic [2:0]                    op_i,
    input  logic                          sub_i,
    input  logic                          cin_i,
    input  logic                          rot_i,
    input  logic                          rot_right_i,
    output logic [SLICE_W*ALU_SLICES-1:0] result_o,
    output logic [7:0]                    flags_o
);
    localparam int unsigned DW   = SLICE_W * ALU_SLICES;
    localparam int unsigned HALF = DW / 2;

    alu_op_e           op_req;
    alu_op_e           op_core;
    logic [DW-1:0]     a_rev;
    logic [DW-1:0]     a_core;
    logic [DW-1:0]     b_core;
    logic [DW-1:0]     y_core;
    logic [DW-1:0]     y_rev;
    logic [DW-1:0]     y_swap;
    logic [DW-1:0]     y_arith;
    logic [ALU_SLICES:0] cy_chain;
    logic [ALU_SLICES:0] eq_chain;
    logic              swap_sel;
    logic              eq_all;
    alu_flags_t        flags_s;

    assign op_req = alu_op_e'(op_i);

    // mirrored bit paths for right rotation
    for (genvar i = 0; i < DW; i++) begin : g_mirror
        assign a_rev[i] = a_i[DW-1-i];
        assign y_rev[i] = y_core[DW-1-i];
    end

    // rotate reuses the adder as A+A; since A+A never propagates,
    // the top carry is the operand MSB, injected at the bottom
    assign op_core     = rot_i ? OP_ADD : op_req;
    assign a_core      = (rot_i && rot_right_i) ? a_rev : a_i;
    assign b_core      = rot_i ? a_core : b_i;
    assign cy_chain[0] = rot_i ? a_core[DW-1] : cin_i;
    assign eq_chain[0] = 1'b1;

    for (genvar s = 0; s < ALU_SLICES; s++) begin : g_slice
        alu_slice #(.W(SLICE_W)) u_slice (
            .a_i    (a_core[s*SLICE_W +: SLICE_W]),
            .b_i    (b_core[s*SLICE_W +: SLICE_W]),
            .op_i   (op_core),
            .cin_i  (cy_chain[s]),
            .eq_i   (eq_chain[s]),
            .y_o    (y_core[s*SLICE_W +: SLICE_W]),
            .cout_o (cy_chain[s+1]),
            .eq_o   (eq_chain[s+1])
        );
    end

    // equality is judged on the external operands, not the rotate path
    assign eq_all = rot_i ? (a_i == b_i) : eq_chain[ALU_SLICES];

    assign y_arith  = (rot_i && rot_right_i) ? y_rev : y_core;
    assign y_swap   = {a_i[HALF-1:0], a_i[DW-1:HALF]};
    assign swap_sel = op_i[2] & op_i[1] & op_i[0] & ~rot_i;
    assign result_o = swap_sel ? y_swap : y_arith;

    alu_flags #(.DW(DW)) u_flags (
        .a_i     (a_i),
        .y_i     (result_o),
        .sub_i   (sub_i),
        .eq_i    (eq_all),
        .cy_i    (cy_chain[ALU_SLICES:1]),
        .flags_o (flags_s)
    );

    assign flags_o = flags_s;

    always_comb begin
        if (!rot_i && op_req == OP_ADD) begin
            assert_add_sum_R1: assert ({cy_chain[ALU_SLICES], result_o}
                                       == ({1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i}))
                else $error("add result mismatch");
        end
        if (rot_i) begin
            assert_rot_wrap_R9: assert (cy_chain[ALU_SLICES] == cy_chain[0])
                else $error("wrapped carry differs from top carry");
        end
        if (rot_i && !rot_right_i) begin
            assert_rot_left_R9: assert (result_o == {a_i[DW-2:0], a_i[DW-1]})
                else $error("rotate left mismatch");
        end
        if (swap_sel) begin
            assert_swap_R4: assert (result_o[DW-1:HALF] == a_i[HALF-1:0]
                                    && result_o[HALF-1:0] == a_i[DW-1:HALF])
                else $error("byte exchange mismatch");
        end
        assert_eq_R6: assert (flags_s.eq == (a_i == b_i))
            else $error("equality flag mismatch");
    end

endmodule

// File: tb/tb_alu16.sv
module tb_alu16;

    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] a;
        logic [15:0] b;
        logic        cin;
        logic        sub;
        logic        rot;
        logic        dir;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [0:NV-1] = '{
        '{3'd0, 16'h7FFF, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0},
        '{3'd0, 16'hFFFF, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0},
        '{3'd0, 16'h0F0F, 16'h0101, 1'b1, 1'b0, 1'b0, 1'b0},
        '{3'd1, 16'h1234, 16'h1234, 1'b1, 1'b1, 1'b0, 1'b0},
        '{3'd1, 16'h8000, 16'h0001, 1'b1, 1'b1, 1'b0, 1'b0},
        '{3'd1, 16'h0000, 16'h0001, 1'b1, 1'b1, 1'b0, 1'b0},
        '{3'd2, 16'hF0F0, 16'hFF00, 1'b1, 1'b0, 1'b0, 1'b0},
        '{3'd3, 16'hF0F0, 16'h0F00, 1'b0, 1'b0, 1'b0, 1'b0},
        '{3'd4, 16'hAAAA, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0},
        '{3'd5, 16'h00FF, 16'h1111, 1'b1, 1'b0, 1'b0, 1'b0},
        '{3'd6, 16'h1234, 16'h8001, 1'b0, 1'b0, 1'b0, 1'b0},
        '{3'd7, 16'hAB12, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0},
        '{3'd3, 16'h8421, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0},
        '{3'd0, 16'h8421, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1}
    };

    logic        clk;
    logic        rst;
    logic [15:0] a, b, result;
    logic [2:0]  op;
    logic        sub, cin, rot, rdir;
    logic [7:0]  flags;
    int          n_checks;
    int          n_fail;
    logic        done;

    alu16 dut (
        .a_i        (a),
        .b_i        (b),
        .op_i       (op),
        .sub_i      (sub),
        .cin_i      (cin),
        .rot_i      (rot),
        .rot_right_i(rdir),
        .result_o   (result),
        .flags_o    (flags)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // reference: {result[15:0], ovf, zero, neg, eq, carries[3:0]}
    function automatic logic [23:0] ref_alu(vec_t v);
        logic [15:0] bb, r;
        logic [3:0]  cy;
        logic [16:0] s16;
        logic [4:0]  s4;
        logic [8:0]  s8;
        logic [12:0] s12;
        logic        o, z, n, e;
        cy = 4'b0;
        r  = 16'h0;
        if (v.rot) begin
            if (!v.dir) begin
                r  = {v.a[14:0], v.a[15]};
                cy = {v.a[15], v.a[11], v.a[7], v.a[3]};
            end else begin
                r  = {v.a[0], v.a[15:1]};
                cy = {v.a[0], v.a[4], v.a[8], v.a[12]};
            end
        end else begin
            case (v.op)
                3'd0, 3'd1: begin
                    bb  = (v.op == 3'd1) ? ~v.b : v.b;
                    s16 = {1'b0, v.a} + {1'b0, bb} + {16'h0, v.cin};
                    s4  = {1'b0, v.a[3:0]} + {1'b0, bb[3:0]} + {4'h0, v.cin};
                    s8  = {1'b0, v.a[7:0]} + {1'b0, bb[7:0]} + {8'h0, v.cin};
                    s12 = {1'b0, v.a[11:0]} + {1'b0, bb[11:0]} + {12'h0, v.cin};
                    r   = s16[15:0];
                    cy  = {s16[16], s12[12], s8[8], s4[4]};
                end
                3'd2: r = v.a & v.b;
                3'd3: r = v.a | v.b;
                3'd4: r = v.a ^ v.b;
                3'd5: r = ~v.a;
                3'd6: r = v.b;
                default: r = {v.a[7:0], v.a[15:8]};
            endcase
        end
        e = (v.a == v.b);
        n = r[15];
        z = (r == 16'h0) || (v.a == 16'h0);
        o = (~(v.a[15] | v.sub) & r[15]) | (v.a[15] & ~r[15]);
        return {r, o, z, n, e, cy};
    endfunction

    function automatic string op_tag(vec_t v);
        if (v.rot) return v.dir ? "R10" : "R9";
        case (v.op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd7: return "R4";
            default: return "R3";
        endcase
    endfunction

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run_vec(vec_t v);
        logic [23:0] exp;
        @(negedge clk);
        a = v.a; b = v.b; op = v.op; cin = v.cin; sub = v.sub; rot = v.rot; rdir = v.dir;
        #2;
        exp = ref_alu(v);
        check(op_tag(v), "result", result, exp[23:8]);
        check(v.rot ? op_tag(v) : (v.op < 3'd2 ? "R5" : op_tag(v)), "carries",
              {12'h0, flags[3:0]}, {12'h0, exp[3:0]});
        check("R6 R7 R8", "eq/neg/zero/ovf", {12'h0, flags[7:4]}, {12'h0, exp[7:4]});
    endtask

    initial begin
        done = 1'b0;
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] corners [4];
        vec_t        v;
        n_checks = 0;
        n_fail   = 0;
        corners[0] = 16'h0000; corners[1] = 16'h7FFF;
        corners[2] = 16'h8000; corners[3] = 16'hFFFF;
        rst = 1'b1;
        a = '0; b = '0; op = '0; sub = 1'b0; cin = 1'b0; rot = 1'b0; rdir = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        #2;
        // idle inputs after reset: zero result, EQ and Z set (R6, R7)
        check("R7", "reset result", result, 16'h0000);
        check("R6 R7", "reset flags", {8'h0, flags}, 16'h0050);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R9: op, B and cin have no effect while rotating
        for (int k = 0; k < 8; k++) begin
            v = '{3'(k), 16'hC3A5, 16'(k * 16'h1357), k[0], 1'b0, 1'b1, 1'b0};
            run_vec(v);
            check("R9", "rotate ignores op/B/cin", result, 16'h874B);
        end

        for (int ia = 0; ia < 4; ia++)
            for (int ib = 0; ib < 4; ib++)
                for (int o = 0; o < 10; o++)
                    for (int c = 0; c < 2; c++) begin
                        v.a   = corners[ia];
                        v.b   = corners[ib];
                        v.op  = (o < 8) ? 3'(o) : 3'd0;
                        v.rot = (o >= 8);
                        v.dir = (o == 9);
                        v.cin = c[0];
                        v.sub = (o == 1);
                        run_vec(v);
                    end

        for (int i = 0; i < 400; i++) begin
            v.a   = 16'($urandom);
            v.b   = (i % 7 == 0) ? v.a : 16'($urandom);
            v.op  = 3'($urandom_range(0, 7));
            v.cin = 1'($urandom);
            v.sub = 1'($urandom);
            v.rot = (i % 5 == 0);
            v.dir = 1'($urandom);
            run_vec(v);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule